// File: doc/BRIEF.md
# Sliced VBI Data Host Register Window

This block is the host-facing register window that sits behind a vertical-blanking data slicer in a video decoder. The slicer hands over decoded service payloads one byte per cycle: closed caption for either field, WSS/CGMS for either field, VPS/Gemstar, VITC and teletext. Each payload lands in one of two places. The first is a read-only bank of dedicated readback bytes. The second is a shared 512-byte FIFO, where a two-byte header goes in ahead of the payload bytes. Teletext always goes to the FIFO. Each of the other six services has a routing bit that picks its destination.

The host sees a byte-wide register port. Reads return data one cycle after the request. A status byte carries sticky data-available flags, which the host clears by writing ones. The FIFO drains through a single address, and only while an enable bit in a control byte is set.

Top module: `vbi_host_regs`

## Requirements
- R1: Service codes are CC field 1 = 0, CC field 2 = 1, WSS field 1 = 2, WSS field 2 = 3, VPS/Gemstar = 4, VITC = 5, teletext = 6. Payload lengths are 2, 2, 3, 3, 13, 9 bytes, and TTX_LEN (default 42) bytes for teletext.
- R2: A payload routed to the bank stores its bytes in arrival order, starting at the service's base address: 0x90 (CC1), 0x92 (CC2), 0x94 (WSS1), 0x97 (WSS2), 0x9A (VPS), 0xA7 (VITC). A host read returns the byte in the cycle after the request, and host writes to the bank are ignored.
- R3: Bit n of `route_fifo_i` (n = service code 0..5) set to 1 sends that service to the FIFO. Teletext always goes to the FIFO. A payload sent to the FIFO leaves the bank unchanged.
- R4: A payload sent to the FIFO is stored as the service code byte, then the length byte, then the payload bytes.
- R5: A read of 0xB0 while bit 0 of 0xCD is 1 returns the oldest FIFO byte and removes it. If the FIFO is empty, the read returns 0x00.
- R6: While bit 0 of 0xCD is 0, a read of 0xB0 returns 0x00 and removes nothing.
- R7: Status at 0xC6 reads, from bit 7 down to bit 0: FIFO overflow error, FIFO empty, teletext, CC1, CC2, WSS (either field), VPS/Gemstar, VITC.
- R8: A service flag is set when the last byte of a bank-routed payload arrives. The teletext flag is set when the last teletext byte is queued. Once set, a flag stays set until the host clears it.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it as it is. Bit 6 cannot be written.
- R10: If a flag is set and cleared in the same cycle, the set wins.
- R11: The FIFO holds 512 bytes. A byte that arrives while the FIFO is full is dropped and sets bit 7.
- R12: Bit 6 follows the live FIFO state and reads 1 whenever the FIFO is empty.
- R13: Reads of unmapped addresses return 0x00. 0xCD reads back its bit 0 and 0 in all other bits.
- R14: After reset, status reads 0x40, 0xCD reads 0x00, and every bank byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slc_valid_i | input | 1 | Slicer byte valid |
| slc_sop_i | input | 1 | First byte of a payload |
| slc_svc_i | input | 3 | Service code, sampled with the first byte |
| slc_byte_i | input | 8 | Payload byte |
| route_fifo_i | input | 6 | Per-service FIFO routing, sampled at the first byte |
| host_we_i | input | 1 | Host write strobe |
| host_re_i | input | 1 | Host read strobe |
| host_addr_i | input | 8 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Read data, one cycle after the read, 0x00 otherwise |

## Verification
The assertions rely on three properties of the slicer. Each payload has exactly the length given for its service. Its first byte carries `slc_sop_i`. At least two idle cycles separate one payload's last byte from the next payload's first byte, which keeps the FIFO write port free for the header. The bench drives payloads only through a task that sends the exact length and then idles for three cycles. The single same-cycle case it stages by hand is a status clear that lands on a final byte, which is within those rules.

// File: rtl/vbi_pkg.sv
package vbi_pkg;
  typedef enum logic [2:0] {
    SVC_CC1  = 3'd0,
    SVC_CC2  = 3'd1,
    SVC_WSS1 = 3'd2,
    SVC_WSS2 = 3'd3,
    SVC_VPS  = 3'd4,
    SVC_VITC = 3'd5,
    SVC_TTX  = 3'd6
  } svc_e;

  localparam int          NUM_ROUTED = 6;
  localparam int          BANK_BYTES = 32;
  localparam int          BANK_AW    = $clog2(BANK_BYTES);
  localparam logic [7:0]  ADDR_BANK  = 8'h90;
  localparam logic [7:0]  ADDR_BLAST = 8'hAF;
  localparam logic [7:0]  ADDR_FIFO  = 8'hB0;
  localparam logic [7:0]  ADDR_STAT  = 8'hC6;
  localparam logic [7:0]  ADDR_CTRL  = 8'hCD;
  localparam logic [7:0]  STAT_W1C   = 8'hBF;

  function automatic logic [5:0] svc_len(input logic [2:0] s, input logic [5:0] ttx);
    case (s)
      3'd0, 3'd1: svc_len = 6'd2;
      3'd2, 3'd3: svc_len = 6'd3;
      3'd4:       svc_len = 6'd13;
      3'd5:       svc_len = 6'd9;
      default:    svc_len = ttx;
    endcase
  endfunction

  function automatic logic [BANK_AW-1:0] svc_base(input logic [2:0] s);
    case (s)
      3'd0:    svc_base = BANK_AW'(0);
      3'd1:    svc_base = BANK_AW'(2);
      3'd2:    svc_base = BANK_AW'(4);
      3'd3:    svc_base = BANK_AW'(7);
      3'd4:    svc_base = BANK_AW'(10);
      default: svc_base = BANK_AW'(23);
    endcase
  endfunction

  function automatic logic [7:0] svc_flag(input logic [2:0] s);
    case (s)
      3'd0:       svc_flag = 8'h10;
      3'd1:       svc_flag = 8'h08;
      3'd2, 3'd3: svc_flag = 8'h04;
      3'd4:       svc_flag = 8'h02;
      3'd5:       svc_flag = 8'h01;
      3'd6:       svc_flag = 8'h20;
      default:    svc_flag = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/vbi_byte_fifo.sv
module vbi_byte_fifo #(
  parameter int DEPTH = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic [7:0] din_i,
  input  logic       pop_i,
  output logic [7:0] dout_o,
  output logic       empty_o,
  output logic       full_o,
  output logic       drop_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign drop_o  = push_i && full_o;
  assign dout_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  p_full_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !pop_i) |=> full_o);
  p_pop_moves_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_no_pop_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/vbi_ingest.sv
module vbi_ingest
  import vbi_pkg::*;
#(
  parameter int TTX_LEN = 42
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               sop_i,
  input  logic [2:0]         svc_i,
  input  logic [7:0]         byte_i,
  input  logic [5:0]         route_fifo_i,
  output logic               bank_we_o,
  output logic [BANK_AW-1:0] bank_idx_o,
  output logic [7:0]         bank_wdata_o,
  output logic               fifo_push_o,
  output logic [7:0]         fifo_din_o,
  output logic [7:0]         flag_set_o
);
  localparam logic [5:0] TTX_L = 6'(TTX_LEN);

  logic [2:0] svc_q, cur_svc;
  logic [5:0] idx_q, cur_idx;
  logic       fifo_q, cur_fifo, cur_last;
  logic [7:0] route_ext;
  logic       hdr0, cnt_pend_q;
  logic [7:0] cnt_byte_q;
  logic       d1_v, d2_v, d1_tl, d2_tl;
  logic [7:0] d1_b, d2_b;
  logic [7:0] ded_flag;

  assign route_ext = {2'b00, route_fifo_i};

  always_comb begin
    cur_svc  = sop_i ? svc_i : svc_q;
    cur_idx  = sop_i ? 6'd0 : idx_q;
    cur_fifo = sop_i ? ((svc_i == SVC_TTX) || route_ext[svc_i]) : fifo_q;
    cur_last = (cur_idx == svc_len(cur_svc, TTX_L) - 6'd1);
  end

  assign bank_we_o    = valid_i && !cur_fifo;
  assign bank_idx_o   = svc_base(cur_svc) + cur_idx[BANK_AW-1:0];
  assign bank_wdata_o = byte_i;
  assign ded_flag     = (valid_i && !cur_fifo && cur_last) ? svc_flag(cur_svc) : 8'h00;
  assign hdr0         = valid_i && sop_i && cur_fifo;

  // header type now, length next cycle, payload two cycles behind arrival
  always_comb begin
    fifo_push_o = hdr0 || cnt_pend_q || d2_v;
    if (hdr0)            fifo_din_o = {5'd0, svc_i};
    else if (cnt_pend_q) fifo_din_o = cnt_byte_q;
    else                 fifo_din_o = d2_b;
  end

  assign flag_set_o = ded_flag | ((d2_v && d2_tl) ? 8'h20 : 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_q      <= '0;
      idx_q      <= '0;
      fifo_q     <= 1'b0;
      cnt_pend_q <= 1'b0;
      cnt_byte_q <= '0;
      d1_v <= 1'b0; d1_b <= '0; d1_tl <= 1'b0;
      d2_v <= 1'b0; d2_b <= '0; d2_tl <= 1'b0;
    end else begin
      if (valid_i) begin
        svc_q  <= cur_svc;
        idx_q  <= cur_idx + 6'd1;
        fifo_q <= cur_fifo;
      end
      cnt_pend_q <= hdr0;
      if (hdr0) cnt_byte_q <= {2'b00, svc_len(svc_i, TTX_L)};
      d1_v  <= valid_i && cur_fifo;
      d1_b  <= byte_i;
      d1_tl <= cur_last && (cur_svc == SVC_TTX);
      d2_v  <= d1_v;
      d2_b  <= d1_b;
      d2_tl <= d1_tl;
    end
  end

  p_port_free_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((hdr0 || cnt_pend_q) && d2_v));
  p_hdr_order_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr0 |=> (fifo_push_o && !hdr0));
  p_bank_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sop_i && svc_i == SVC_TTX) |-> !bank_we_o);
endmodule

// File: rtl/vbi_status.sv
module vbi_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] set_i,
  input  logic       clr_we_i,
  input  logic [7:0] clr_i,
  input  logic       fifo_empty_i,
  output logic [7:0] stat_o
);
  import vbi_pkg::*;

  logic [7:0] sticky_q, eff_clr, eff_set;

  assign eff_clr = clr_we_i ? (clr_i & STAT_W1C) : 8'h00;
  assign eff_set = set_i & STAT_W1C;
  assign stat_o  = {sticky_q[7], fifo_empty_i, sticky_q[5:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sticky_q <= '0;
    else         sticky_q <= (sticky_q & ~eff_clr) | eff_set;
  end

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff_set != 8'h00) |=> ((stat_o & $past(eff_set)) == $past(eff_set)));
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i == 1'b0) |=> ((stat_o & $past(sticky_q & STAT_W1C)) == $past(sticky_q & STAT_W1C)));
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((eff_clr & ~eff_set) != 8'h00) |=> ((stat_o & $past(eff_clr & ~eff_set)) == 8'h00));
endmodule

// File: rtl/vbi_host_regs.sv
module vbi_host_regs
  import vbi_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int TTX_LEN    = 42
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       slc_valid_i,
  input  logic       slc_sop_i,
  input  logic [2:0] slc_svc_i,
  input  logic [7:0] slc_byte_i,
  input  logic [5:0] route_fifo_i,
  input  logic       host_we_i,
  input  logic       host_re_i,
  input  logic [7:0] host_addr_i,
  input  logic [7:0] host_wdata_i,
  output logic [7:0] host_rdata_o
);
  logic               bank_we;
  logic [BANK_AW-1:0] bank_idx;
  logic [7:0]         bank_wdata;
  logic               fifo_push, fifo_pop, fifo_empty, fifo_full, fifo_drop;
  logic [7:0]         fifo_din, fifo_dout;
  logic [7:0]         ing_set, stat;
  logic [7:0]         bank_q [BANK_BYTES];
  logic               ctrl_en_q;
  logic [7:0]         bank_off, rd_next, rdata_q;
  logic               in_bank, rd_fifo, unmapped;

  vbi_ingest #(.TTX_LEN(TTX_LEN)) u_ingest (
    .clk_i, .rst_ni,
    .valid_i(slc_valid_i), .sop_i(slc_sop_i), .svc_i(slc_svc_i), .byte_i(slc_byte_i),
    .route_fifo_i,
    .bank_we_o(bank_we), .bank_idx_o(bank_idx), .bank_wdata_o(bank_wdata),
    .fifo_push_o(fifo_push), .fifo_din_o(fifo_din), .flag_set_o(ing_set)
  );

  vbi_byte_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(fifo_push), .din_i(fifo_din), .pop_i(fifo_pop), .dout_o(fifo_dout),
    .empty_o(fifo_empty), .full_o(fifo_full), .drop_o(fifo_drop)
  );

  vbi_status u_status (
    .clk_i, .rst_ni,
    .set_i(ing_set | {fifo_drop, 7'd0}),
    .clr_we_i(host_we_i && host_addr_i == ADDR_STAT),
    .clr_i(host_wdata_i),
    .fifo_empty_i(fifo_empty),
    .stat_o(stat)
  );

  assign bank_off = host_addr_i - ADDR_BANK;
  assign in_bank  = (host_addr_i >= ADDR_BANK) && (host_addr_i <= ADDR_BLAST);
  assign rd_fifo  = host_re_i && host_addr_i == ADDR_FIFO;
  assign fifo_pop = rd_fifo && ctrl_en_q && !fifo_empty;
  assign unmapped = !in_bank && host_addr_i != ADDR_FIFO &&
                    host_addr_i != ADDR_STAT && host_addr_i != ADDR_CTRL;

  always_comb begin
    rd_next = 8'h00;
    if (in_bank) rd_next = bank_q[bank_off[BANK_AW-1:0]];
    else begin
      case (host_addr_i)
        ADDR_FIFO: if (ctrl_en_q && !fifo_empty) rd_next = fifo_dout;
        ADDR_STAT: rd_next = stat;
        ADDR_CTRL: rd_next = {7'd0, ctrl_en_q};
        default:   rd_next = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BANK_BYTES; i++) bank_q[i] <= '0;
      ctrl_en_q <= 1'b0;
      rdata_q   <= '0;
    end else begin
      if (bank_we) bank_q[bank_idx] <= bank_wdata;
      if (host_we_i && host_addr_i == ADDR_CTRL) ctrl_en_q <= host_wdata_i[0];
      rdata_q <= host_re_i ? rd_next : 8'h00;
    end
  end

  assign host_rdata_o = rdata_q;

  p_fifo_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fifo && !ctrl_en_q) |=> (host_rdata_o == 8'h00));
  p_unmapped_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_re_i && unmapped) |=> (host_rdata_o == 8'h00));
  p_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_re_i |=> (host_rdata_o == 8'h00));
endmodule

// File: tb/sim_vbi_host_regs.sv
`timescale 1ns/1ps
module sim_vbi_host_regs;
  localparam int DEPTH = 512;
  localparam int TTXL  = 42;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       slc_valid_i = 0, slc_sop_i = 0;
  logic [2:0] slc_svc_i = 0;
  logic [7:0] slc_byte_i = 0;
  logic [5:0] route_fifo_i = 0;
  logic       host_we_i = 0, host_re_i = 0;
  logic [7:0] host_addr_i = 0, host_wdata_i = 0;
  logic [7:0] host_rdata_o;

  int n_chk = 0, n_fail = 0;
  bit started = 0;
  string cur_tag = "R14", exp_tag = "R14";

  always #2 clk_i = ~clk_i;

  vbi_host_regs #(.FIFO_DEPTH(DEPTH), .TTX_LEN(TTXL)) u0 (.*);

  function automatic int len_of(int s);
    case (s) 0, 1: return 2; 2, 3: return 3; 4: return 13; 5: return 9; default: return TTXL; endcase
  endfunction
  function automatic int base_of(int s);
    case (s) 0: return 0; 1: return 2; 2: return 4; 3: return 7; 4: return 10; default: return 23; endcase
  endfunction
  function automatic int flag_of(int s);
    case (s) 0: return 4; 1: return 3; 2, 3: return 2; 4: return 1; 5: return 0; default: return 5; endcase
  endfunction

  // reference model
  logic [7:0] m_bank [32];
  bit [7:0]   m_q [$];
  logic [7:0] m_flags, exp_rd;
  bit         m_en, m_fifo, m_hp, m_d1v, m_d2v, m_d1t, m_d2t;
  int         m_svc, m_idx;
  logic [7:0] m_hcnt, m_d1b, m_d2b;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      foreach (m_bank[i]) m_bank[i] = 0;
      m_q.delete(); m_flags = 0; exp_rd = 0; m_en = 0; m_hp = 0;
      m_d1v = 0; m_d2v = 0; m_d1t = 0; m_d2t = 0; m_svc = 0; m_idx = 0; m_fifo = 0;
    end else begin
      automatic int sz0 = m_q.size();
      automatic bit pv = 0;
      automatic logic [7:0] pb = 0, setv = 0;
      automatic bit last = 0;
      automatic logic [7:0] rext = {2'b00, route_fifo_i};
      exp_tag = cur_tag;
      exp_rd = 0;
      if (host_re_i) begin
        if (host_addr_i >= 8'h90 && host_addr_i <= 8'hAF) exp_rd = m_bank[host_addr_i - 8'h90];
        else if (host_addr_i == 8'hB0) begin
          if (m_en && sz0 > 0) exp_rd = m_q.pop_front();
        end else if (host_addr_i == 8'hC6) exp_rd = {m_flags[7], sz0 == 0, m_flags[5:0]};
        else if (host_addr_i == 8'hCD) exp_rd = {7'd0, m_en};
      end
      if (m_hp)  begin pv = 1; pb = m_hcnt; end
      if (m_d2v) begin pv = 1; pb = m_d2b; if (m_d2t) setv[5] = 1; end
      m_hp = 0;
      m_d2v = m_d1v; m_d2b = m_d1b; m_d2t = m_d1t; m_d1v = 0; m_d1t = 0;
      if (slc_valid_i) begin
        if (slc_sop_i) begin
          m_svc = slc_svc_i; m_idx = 0;
          m_fifo = (slc_svc_i == 6) || rext[slc_svc_i];
          if (m_fifo) begin pv = 1; pb = 8'(slc_svc_i); m_hp = 1; m_hcnt = 8'(len_of(m_svc)); end
        end
        last = (m_idx == len_of(m_svc) - 1);
        if (m_fifo) begin m_d1v = 1; m_d1b = slc_byte_i; m_d1t = last && m_svc == 6; end
        else begin
          m_bank[base_of(m_svc) + m_idx] = slc_byte_i;
          if (last) setv[flag_of(m_svc)] = 1;
        end
        m_idx++;
      end
      if (pv) begin
        if (sz0 >= DEPTH) setv[7] = 1; else m_q.push_back(pb);
      end
      if (host_we_i && host_addr_i == 8'hC6) m_flags = m_flags & ~(host_wdata_i & 8'hBF);
      m_flags = m_flags | setv;
      if (host_we_i && host_addr_i == 8'hCD) m_en = host_wdata_i[0];
    end
  end

  // per-clock comparison against the model
  always @(negedge clk_i) begin
    if (started) begin
      n_chk++;
      if (host_rdata_o !== exp_rd) begin
        n_fail++;
        $display("FAIL %s (model): got %02h expected %02h", exp_tag, host_rdata_o, exp_rd);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send(int svc, int seed, string tag);
    cur_tag = tag;
    for (int k = 0; k < len_of(svc); k++) begin
      @(negedge clk_i);
      slc_valid_i = 1; slc_sop_i = (k == 0); slc_svc_i = 3'(svc); slc_byte_i = 8'(seed + k);
    end
    @(negedge clk_i);
    slc_valid_i = 0; slc_sop_i = 0;
    idle(2);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    @(negedge clk_i);
    cur_tag = tag; host_we_i = 1; host_addr_i = a; host_wdata_i = d;
    @(negedge clk_i);
    host_we_i = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk_i);
    cur_tag = tag; host_re_i = 1; host_addr_i = a;
    @(negedge clk_i);
    host_re_i = 0;
  endtask

  task automatic rd_exp(logic [7:0] a, logic [7:0] e, string tag);
    rd(a, tag);
    n_chk++;
    if (host_rdata_o !== e) begin
      n_fail++;
      $display("FAIL %s: addr %02h got %02h expected %02h", tag, a, host_rdata_o, e);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #150000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst_ni = 1;
    started = 1;
    // R14 reset state, R13 unmapped and control readback
    rd_exp(8'hC6, 8'h40, "R14");
    rd_exp(8'hCD, 8'h00, "R14");
    rd_exp(8'h9A, 8'h00, "R14");
    rd_exp(8'h50, 8'h00, "R13");
    rd_exp(8'hB1, 8'h00, "R13");
    // R1 R2 dedicated bank per service
    send(0, 8'h11, "R2"); rd_exp(8'h90, 8'h11, "R2"); rd_exp(8'h91, 8'h12, "R2");
    rd_exp(8'hC6, 8'h50, "R8");
    send(2, 8'h30, "R1"); send(3, 8'h40, "R1"); send(4, 8'h50, "R1"); send(5, 8'h70, "R1");
    rd_exp(8'h96, 8'h32, "R1"); rd_exp(8'h97, 8'h40, "R1");
    rd_exp(8'hA6, 8'h5C, "R2"); rd_exp(8'hAF, 8'h78, "R2");
    rd_exp(8'hC6, 8'h57, "R7");
    wr(8'h90, 8'hEE, "R2"); rd_exp(8'h90, 8'h11, "R2");
    // R9 write-one-to-clear
    wr(8'hC6, 8'h00, "R9"); rd_exp(8'hC6, 8'h57, "R9");
    wr(8'hC6, 8'h50, "R9"); rd_exp(8'hC6, 8'h47, "R9");
    wr(8'hC6, 8'hFF, "R9"); rd_exp(8'hC6, 8'h40, "R12");
    // R10 set and clear in the same cycle
    @(negedge clk_i); cur_tag = "R10";
    slc_valid_i = 1; slc_sop_i = 1; slc_svc_i = 3'd1; slc_byte_i = 8'hAA;
    @(negedge clk_i);
    slc_sop_i = 0; slc_byte_i = 8'hBB; host_we_i = 1; host_addr_i = 8'hC6; host_wdata_i = 8'h08;
    @(negedge clk_i);
    slc_valid_i = 0; host_we_i = 0;
    idle(2);
    rd_exp(8'hC6, 8'h48, "R10");
    wr(8'hC6, 8'hFF, "R9");
    // R3 R4 routing to the FIFO, R6 gating
    route_fifo_i = 6'b000001;
    send(0, 8'h21, "R3");
    rd_exp(8'h90, 8'h11, "R3");
    rd_exp(8'hC6, 8'h00, "R12");
    rd_exp(8'hB0, 8'h00, "R6");
    wr(8'hCD, 8'h01, "R13"); rd_exp(8'hCD, 8'h01, "R13");
    rd_exp(8'hB0, 8'h00, "R4"); rd_exp(8'hB0, 8'h02, "R4");
    rd_exp(8'hB0, 8'h21, "R5"); rd_exp(8'hB0, 8'h22, "R5");
    rd_exp(8'hB0, 8'h00, "R5");
    rd_exp(8'hC6, 8'h40, "R12");
    // teletext always to the FIFO
    route_fifo_i = 6'b000000;
    send(6, 8'h80, "R3");
    rd_exp(8'hC6, 8'h20, "R8");
    rd_exp(8'hB0, 8'h06, "R4"); rd_exp(8'hB0, 8'h2A, "R4");
    for (int k = 0; k < TTXL; k++) rd(8'hB0, "R5");
    rd_exp(8'hC6, 8'h60, "R12");
    wr(8'hC6, 8'hFF, "R9");
    // R11 overflow: 12 x 44 bytes into 512
    wr(8'hCD, 8'h00, "R6");
    for (int p = 0; p < 12; p++) send(6, p * 16, "R11");
    rd_exp(8'hC6, 8'hA0, "R11");
    rd_exp(8'hB0, 8'h00, "R6");
    wr(8'hCD, 8'h01, "R5");
    for (int k = 0; k < DEPTH; k++) rd(8'hB0, "R11");
    rd_exp(8'hB0, 8'h00, "R5");
    rd_exp(8'hC6, 8'hE0, "R12");
    idle(4);
    finish_run();
  end
endmodule